// File: doc/BRIEF.md
# DMA Descriptor and Report Ring Port

This block sits between a processor's register bus and one channel of a DMA transfer engine. It holds two small circular queues. The descriptor queue is filled by software and emptied by the engine. The report queue is filled by the engine and emptied by software. Each entry is four 32-bit words. Software moves an entry with four consecutive accesses to a single port address: writes for a descriptor, reads for a report. A word counter on each side tracks the position within the four-word burst. A descriptor becomes visible to the engine only after its fourth word. A report leaves the queue only after its fourth word has been read.

Each queue has a status word. It shows the raw write and read slot pointers, the full and empty flags, and a sticky error flag that software clears by writing one to it. Writing to a descriptor port that is full, or reading from a report port that is empty, raises that error and changes nothing else. A control bit holds both queues and both word counters in their cleared state for as long as it is set.

When the engine retires the descriptor at the head of the queue, the block pushes a report built from the engine's transfer count, an extra word, and the descriptor's flags. If that descriptor asked for notification, the block also pulses a done event.

Top module: `dma_ring_port`

## Requirements
- R1: After reset, both status words read 0x100: pointers 0, empty set, full clear, error clear. The engine sees no valid descriptor and `desc_done` is low.
- R2: A status word has this layout: write pointer in bits [1:0], read pointer in bits [5:4], empty in bit 8, full in bit 9, error in bit 10. The descriptor status is at byte offset 0x04 and the report status is at 0x08.
- R3: A descriptor is written as four words to offset 0x10, in this order: address low, address high, length, flags. The queue and its status stay unchanged until the fourth word, which commits the entry for the engine.
- R4: The descriptor queue holds at most 4 entries. A descriptor word written while the queue is full sets the error flag. That word is dropped, and the head entry and pointers stay unchanged.
- R5: A report is read as four words from offset 0x14, in this order: count low, count high, extra word, flags. The report is removed only after the fourth read.
- R6: A read from offset 0x14 while the report queue is empty, at the first word of a burst, returns 0 and sets the report error flag. The pointers stay unchanged.
- R7: The error flag is sticky. Writing a status word with bit 10 set clears it. Writing it with bit 10 clear leaves it set.
- R8: Writing 1 to bit 0 of the control register at offset 0x00 empties both queues and discards any partly written descriptor, for as long as the bit stays set. Writing 0 releases the clear.
- R9: When the engine retires a descriptor from a non-empty queue, a report is pushed that holds {descriptor flags, extra, count}. If the report queue is full, the report is dropped and the report error flag is set.
- R10: `desc_done` pulses high for exactly one cycle, in the cycle after the retire, when bit 16 of the retired descriptor's flags is set. Otherwise it stays low.
- R11: A retire request while the descriptor queue is empty has no effect: no report is pushed and no done pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe (a read of the report port consumes a word) |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as the read strobe |
| eng_desc_valid | output | 1 | Descriptor queue holds at least one entry |
| eng_desc_addr | output | 2*DATA_W | Buffer address of the head descriptor |
| eng_desc_len | output | DATA_W | Byte length of the head descriptor |
| eng_desc_flags | output | DATA_W | Flags of the head descriptor |
| eng_retire | input | 1 | Engine has finished the head descriptor |
| eng_count | input | 2*DATA_W | Transfer count carried into the report |
| eng_extra | input | DATA_W | Extra word carried into the report |
| desc_done | output | 1 | One-cycle notify event for a retired descriptor |

## Verification
Read data is combinational, so the bench samples `bus_rdata` in the same cycle as the read strobe, before the clock edge that consumes the word. Pointers, flags and head fields change at the edge that ends a write or retire cycle. The bench checks them at the following falling edge, one cycle after the stimulus. `desc_done` is registered: it is due at the falling edge right after the retire edge, and it must be low again one cycle later. Each directed task checks its own results at exactly those points, and the status words are re-read between words of a burst to show that nothing commits early.

// File: rtl/ring_pkg.sv
package ring_pkg;
   localparam int WORDS        = 4;
   localparam int OFS_CTRL     = 'h00;
   localparam int OFS_DSTAT    = 'h04;
   localparam int OFS_RSTAT    = 'h08;
   localparam int OFS_DPORT    = 'h10;
   localparam int OFS_RPORT    = 'h14;
   localparam int ST_RD_LSB    = 4;
   localparam int ST_EMPTY     = 8;
   localparam int ST_FULL      = 9;
   localparam int ST_ERR       = 10;
   localparam int NOTIFY_BIT   = 16;
   localparam int CTRL_CLR_BIT = 0;

   function automatic logic [31:0] pack_status(input logic [3:0] wp, input logic [3:0] rp,
                                               input logic emp, input logic ful, input logic er);
      logic [31:0] s;
      s = '0;
      s[3:0]                   = wp;
      s[ST_RD_LSB+3:ST_RD_LSB] = rp;
      s[ST_EMPTY]              = emp;
      s[ST_FULL]               = ful;
      s[ST_ERR]                = er;
      return s;
   endfunction
endpackage

// File: rtl/word_seq.sv
module word_seq #(
   parameter int WORDS = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         step,
   output logic [$clog2(WORDS)-1:0]     idx,
   output logic                         last
);
   localparam int IDX_W = $clog2(WORDS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);
   localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

   initial assert (WORDS >= 2) else $error("word_seq: WORDS must be at least 2");

   logic [IDX_W-1:0] idx_q;

   generate
      if ((WORDS & (WORDS - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)     idx_q <= '0;
            else if (clr)   idx_q <= '0;
            else if (step)  idx_q <= idx_q + ONE;
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)     idx_q <= '0;
            else if (clr)   idx_q <= '0;
            else if (step)  idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + ONE;
      end
   endgenerate

   assign idx  = idx_q;
   assign last = (idx_q == LAST_IDX);

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(idx_q) < WORDS);                                          // R3
   AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      step && !clr && !last |=> idx_q == $past(idx_q) + ONE);        // R3
endmodule

// File: rtl/ring_store.sv
module ring_store #(
   parameter int DEPTH   = 4,
   parameter int ENTRY_W = 128
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic [ENTRY_W-1:0]         push_data,
   input  logic                       pop,
   input  logic                       err_set,
   input  logic                       err_clr,
   output logic [ENTRY_W-1:0]         head,
   output logic [$clog2(DEPTH)-1:0]   wptr,
   output logic [$clog2(DEPTH)-1:0]   rptr,
   output logic                       full,
   output logic                       empty,
   output logic                       err
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

   initial assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
      else $error("ring_store: DEPTH must be a power of two, at least 2");

   logic [ENTRY_W-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0]   wptr_q, rptr_q;
   logic               full_q, empty_q, err_q;
   logic               do_push, do_pop;

   assign do_pop  = pop & ~empty_q;
   assign do_push = push & (~full_q | do_pop);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      end else if (do_push && !clr) begin
         for (int i = 0; i < DEPTH; i++)
            if (int'(wptr_q) == i) slot_q[i] <= push_data;
      end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         full_q  <= 1'b0;
         empty_q <= 1'b1;
         err_q   <= 1'b0;
      end else if (clr) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         full_q  <= 1'b0;
         empty_q <= 1'b1;
         err_q   <= 1'b0;
      end else begin
         if (do_push) wptr_q <= wptr_q + ONE;
         if (do_pop)  rptr_q <= rptr_q + ONE;
         if (do_push && !do_pop) begin
            empty_q <= 1'b0;
            full_q  <= ((wptr_q + ONE) == rptr_q);
         end else if (do_pop && !do_push) begin
            full_q  <= 1'b0;
            empty_q <= ((rptr_q + ONE) == wptr_q);
         end
         if (err_set || (push && !do_push)) err_q <= 1'b1;
         else if (err_clr)                  err_q <= 1'b0;
      end

   assign head  = slot_q[rptr_q];
   assign wptr  = wptr_q;
   assign rptr  = rptr_q;
   assign full  = full_q;
   assign empty = empty_q;
   assign err   = err_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_q && empty_q));                                          // R4
   AST_FULL_PUSH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      push && full_q && !pop && !clr |=> err_q && $stable(wptr_q));   // R4
   AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      pop && empty_q && !push && !clr |=> $stable(rptr_q));           // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q && !err_clr && !clr |=> err_q);                           // R7
endmodule

// File: rtl/dma_ring_port.sv
module dma_ring_port
   import ring_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr_en,
   input  logic                  bus_rd_en,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic                  eng_desc_valid,
   output logic [2*DATA_W-1:0]   eng_desc_addr,
   output logic [DATA_W-1:0]     eng_desc_len,
   output logic [DATA_W-1:0]     eng_desc_flags,
   input  logic                  eng_retire,
   input  logic [2*DATA_W-1:0]   eng_count,
   input  logic [DATA_W-1:0]     eng_extra,
   output logic                  desc_done
);
   localparam int ENTRY_W = WORDS * DATA_W;
   localparam int PTR_W   = $clog2(DEPTH);
   localparam int IDX_W   = $clog2(WORDS);

   initial assert (DATA_W > NOTIFY_BIT && DATA_W >= 32)
      else $error("dma_ring_port: DATA_W too narrow for status and flag fields");
   initial assert (PTR_W <= 4)
      else $error("dma_ring_port: slot pointers do not fit their status fields");
   initial assert (ADDR_W >= 5)
      else $error("dma_ring_port: ADDR_W too narrow for the register offsets");

   // register decode
   logic sel_ctrl, sel_dstat, sel_rstat, sel_dport, sel_rport;
   assign sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
   assign sel_dstat = (bus_addr == ADDR_W'(OFS_DSTAT));
   assign sel_rstat = (bus_addr == ADDR_W'(OFS_RSTAT));
   assign sel_dport = (bus_addr == ADDR_W'(OFS_DPORT));
   assign sel_rport = (bus_addr == ADDR_W'(OFS_RPORT));

   logic ctrl_clr_q;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     ctrl_clr_q <= 1'b0;
      else if (bus_wr_en && sel_ctrl) ctrl_clr_q <= bus_wdata[CTRL_CLR_BIT];

   // descriptor side
   logic [IDX_W-1:0]   d_idx;
   logic               d_last, d_step, d_block, d_err_set, d_push, d_pop;
   logic [ENTRY_W-1:0] d_entry, d_head;
   logic [PTR_W-1:0]   d_wptr, d_rptr;
   logic               d_full, d_empty, d_err;
   logic [WORDS-2:0][DATA_W-1:0] stage_q;

   assign d_block   = (d_idx == '0) & d_full;
   assign d_step    = bus_wr_en & sel_dport & ~d_block & ~ctrl_clr_q;
   assign d_err_set = bus_wr_en & sel_dport & d_block;
   assign d_push    = d_step & d_last;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stage_q <= '0;
      else
         for (int k = 0; k < WORDS - 1; k++)
            if (d_step && int'(d_idx) == k) stage_q[k] <= bus_wdata;

   always_comb begin
      for (int k = 0; k < WORDS - 1; k++) d_entry[k*DATA_W +: DATA_W] = stage_q[k];
      d_entry[(WORDS-1)*DATA_W +: DATA_W] = bus_wdata;
   end

   word_seq #(.WORDS(WORDS)) u_dseq (
      .clk(clk), .rst_n(rst_n), .clr(ctrl_clr_q), .step(d_step),
      .idx(d_idx), .last(d_last)
   );

   ring_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_dring (
      .clk(clk), .rst_n(rst_n), .clr(ctrl_clr_q),
      .push(d_push), .push_data(d_entry), .pop(d_pop),
      .err_set(d_err_set), .err_clr(bus_wr_en & sel_dstat & bus_wdata[ST_ERR]),
      .head(d_head), .wptr(d_wptr), .rptr(d_rptr),
      .full(d_full), .empty(d_empty), .err(d_err)
   );

   // engine retire and report side
   logic               retire_ok, notify;
   logic [IDX_W-1:0]   r_idx;
   logic               r_last, r_step, r_block, r_err_set, r_pop;
   logic [ENTRY_W-1:0] r_entry, r_head;
   logic [PTR_W-1:0]   r_wptr, r_rptr;
   logic               r_full, r_empty, r_err;
   logic               done_q;

   assign retire_ok = eng_retire & ~d_empty & ~ctrl_clr_q;
   assign d_pop     = retire_ok;
   assign notify    = d_head[3*DATA_W + NOTIFY_BIT];
   assign r_entry   = {d_head[3*DATA_W +: DATA_W], eng_extra, eng_count};

   assign r_block   = (r_idx == '0) & r_empty;
   assign r_step    = bus_rd_en & sel_rport & ~r_block & ~ctrl_clr_q;
   assign r_err_set = bus_rd_en & sel_rport & r_block;
   assign r_pop     = r_step & r_last;

   word_seq #(.WORDS(WORDS)) u_rseq (
      .clk(clk), .rst_n(rst_n), .clr(ctrl_clr_q), .step(r_step),
      .idx(r_idx), .last(r_last)
   );

   ring_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_rring (
      .clk(clk), .rst_n(rst_n), .clr(ctrl_clr_q),
      .push(retire_ok), .push_data(r_entry), .pop(r_pop),
      .err_set(r_err_set), .err_clr(bus_wr_en & sel_rstat & bus_wdata[ST_ERR]),
      .head(r_head), .wptr(r_wptr), .rptr(r_rptr),
      .full(r_full), .empty(r_empty), .err(r_err)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= retire_ok & notify;

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_rd_en) begin
         if (sel_ctrl)
            bus_rdata[CTRL_CLR_BIT] = ctrl_clr_q;
         else if (sel_dstat)
            bus_rdata = DATA_W'(pack_status(4'(d_wptr), 4'(d_rptr), d_empty, d_full, d_err));
         else if (sel_rstat)
            bus_rdata = DATA_W'(pack_status(4'(r_wptr), 4'(r_rptr), r_empty, r_full, r_err));
         else if (sel_rport && r_step)
            bus_rdata = r_head[int'(r_idx)*DATA_W +: DATA_W];
      end
   end

   assign eng_desc_valid = ~d_empty;
   assign eng_desc_addr  = d_head[0 +: 2*DATA_W];
   assign eng_desc_len   = d_head[2*DATA_W +: DATA_W];
   assign eng_desc_flags = d_head[3*DATA_W +: DATA_W];
   assign desc_done      = done_q;

   AST_DONE_AFTER_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      desc_done |-> $past(eng_retire));                               // R10
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      desc_done && !eng_retire |=> !desc_done);                       // R10
   AST_NO_RETIRE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      eng_retire && !eng_desc_valid |=> !desc_done);                  // R11
   AST_CTRL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_clr_q |=> !eng_desc_valid);                                // R8
   AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_en && sel_rport && r_block |-> bus_rdata == '0);         // R6
endmodule

// File: tb/sim_dma_ring_port.sv
module sim_dma_ring_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        eng_desc_valid;
   logic [63:0] eng_desc_addr;
   logic [31:0] eng_desc_len, eng_desc_flags;
   logic        eng_retire = 1'b0;
   logic [63:0] eng_count = '0;
   logic [31:0] eng_extra = '0;
   logic        desc_done;

   int n_tests = 0, n_fail = 0;

   localparam logic [7:0] A_CTRL = 8'h00, A_DST = 8'h04, A_RST = 8'h08,
                          A_DPORT = 8'h10, A_RPORT = 8'h14;

   always #10 clk = ~clk;

   dma_ring_port u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_desc_valid(eng_desc_valid), .eng_desc_addr(eng_desc_addr),
      .eng_desc_len(eng_desc_len), .eng_desc_flags(eng_desc_flags),
      .eng_retire(eng_retire), .eng_count(eng_count), .eng_extra(eng_extra),
      .desc_done(desc_done)
   );

   function automatic logic [31:0] st(int w, int r, bit e, bit f, bit er);
      return 32'((er << 10) | (f << 9) | (e << 8) | (r << 4) | w);
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd_en = 1'b1; bus_addr = a;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_rd_en = 1'b0;
   endtask

   task automatic push_desc(logic [63:0] ad, logic [31:0] len, logic [31:0] fl);
      bus_wr(A_DPORT, ad[31:0]);
      bus_wr(A_DPORT, ad[63:32]);
      bus_wr(A_DPORT, len);
      bus_wr(A_DPORT, fl);
   endtask

   task automatic retire(logic [63:0] cnt, logic [31:0] ex, bit exp_done, string req);
      @(negedge clk);
      eng_retire = 1'b1; eng_count = cnt; eng_extra = ex;
      @(negedge clk);
      eng_retire = 1'b0;
      #1 check(req, desc_done, exp_done);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      bus_rd(A_DST, d); check("R1 desc status", d, st(0,0,1,0,0));
      bus_rd(A_RST, d); check("R1 report status", d, st(0,0,1,0,0));
      check("R1 valid", eng_desc_valid, 0);
      check("R1 done", desc_done, 0);
   endtask

   task automatic t_push_order();
      logic [31:0] d;
      bus_wr(A_DPORT, 32'h1000_0000);
      bus_wr(A_DPORT, 32'h2);
      bus_wr(A_DPORT, 32'h40);
      bus_rd(A_DST, d); check("R3 no commit before word 4", d, st(0,0,1,0,0));
      check("R3 valid before word 4", eng_desc_valid, 0);
      bus_wr(A_DPORT, 32'h0001_0000);
      bus_rd(A_DST, d); check("R2 status after commit", d, st(1,0,0,0,0));
      check("R3 addr", eng_desc_addr, 64'h2_1000_0000);
      check("R3 len", eng_desc_len, 32'h40);
      check("R3 flags", eng_desc_flags, 32'h0001_0000);
   endtask

   task automatic t_fill_overflow();
      logic [31:0] d;
      push_desc(64'h1100, 32'h80, 32'h0);
      push_desc(64'h1200, 32'h80, 32'h0);
      push_desc(64'h1300, 32'h80, 32'h0001_0000);
      bus_rd(A_DST, d); check("R4 full at 4", d, st(0,0,0,1,0));
      bus_wr(A_DPORT, 32'hDEAD_BEEF);
      bus_rd(A_DST, d); check("R4 write when full", d, st(0,0,0,1,1));
      check("R4 head unchanged", eng_desc_addr, 64'h2_1000_0000);
      bus_wr(A_DST, 32'h0);
      bus_rd(A_DST, d); check("R7 write 0 keeps error", d, st(0,0,0,1,1));
      bus_wr(A_DST, 32'h400);
      bus_rd(A_DST, d); check("R7 write 1 clears error", d, st(0,0,0,1,0));
   endtask

   task automatic t_retire();
      logic [31:0] d;
      retire(64'h1_0000_0005, 32'hAB, 1'b1, "R10 notify done");
      @(negedge clk); #1 check("R10 pulse one cycle", desc_done, 0);
      bus_rd(A_RST, d); check("R9 report pushed", d, st(1,0,0,0,0));
      bus_rd(A_DST, d); check("R9 desc popped", d, st(0,1,0,0,0));
      retire(64'h7, 32'hCD, 1'b0, "R10 no notify");
      bus_rd(A_RST, d); check("R9 second report", d, st(2,0,0,0,0));
   endtask

   task automatic t_report_read();
      logic [31:0] d;
      bus_rd(A_RPORT, d); check("R5 count low", d, 32'h5);
      bus_rd(A_RPORT, d); check("R5 count high", d, 32'h1);
      bus_rd(A_RPORT, d); check("R5 extra", d, 32'hAB);
      bus_rd(A_RST, d);   check("R5 no pop before word 4", d, st(2,0,0,0,0));
      bus_rd(A_RPORT, d); check("R5 flags", d, 32'h0001_0000);
      bus_rd(A_RST, d);   check("R5 pop after word 4", d, st(2,1,0,0,0));
      bus_rd(A_RPORT, d); check("R5 r2 count low", d, 32'h7);
      bus_rd(A_RPORT, d); check("R5 r2 count high", d, 32'h0);
      bus_rd(A_RPORT, d); check("R5 r2 extra", d, 32'hCD);
      bus_rd(A_RPORT, d); check("R5 r2 flags", d, 32'h0);
      bus_rd(A_RST, d);   check("R5 empty after two", d, st(2,2,1,0,0));
   endtask

   task automatic t_underflow();
      logic [31:0] d;
      bus_rd(A_RPORT, d); check("R6 empty read data", d, 32'h0);
      bus_rd(A_RST, d);   check("R6 empty read error", d, st(2,2,1,0,1));
      bus_wr(A_RST, 32'h400);
      bus_rd(A_RST, d);   check("R7 report error cleared", d, st(2,2,1,0,0));
   endtask

   task automatic t_retire_empty();
      logic [31:0] d;
      retire(64'h20, 32'h1, 1'b0, "R10 desc2 no notify");
      retire(64'h21, 32'h2, 1'b1, "R10 desc3 notify");
      bus_rd(A_DST, d); check("R11 desc ring empty", d, st(0,0,1,0,0));
      retire(64'h22, 32'h3, 1'b0, "R11 no done on empty");
      bus_rd(A_RST, d); check("R11 no report on empty", d, st(0,2,0,0,0));
   endtask

   task automatic t_ring_reset();
      logic [31:0] d;
      bus_wr(A_DPORT, 32'h5555);
      bus_wr(A_DPORT, 32'h6);
      bus_wr(A_CTRL, 32'h1);
      bus_rd(A_DST, d); check("R8 desc cleared", d, st(0,0,1,0,0));
      bus_rd(A_RST, d); check("R8 report cleared", d, st(0,0,1,0,0));
      bus_wr(A_CTRL, 32'h0);
      push_desc(64'h7000, 32'h20, 32'h0);
      check("R8 partial burst discarded", eng_desc_addr, 64'h7000);
      bus_rd(A_DST, d); check("R8 push after release", d, st(1,0,0,0,0));
   endtask

   task automatic t_report_full();
      logic [31:0] d;
      for (int i = 1; i < 4; i++) push_desc(64'h7000 + 64'(i) * 64'h100, 32'h20, 32'h0);
      for (int i = 0; i < 4; i++) retire(64'h10 + 64'(i), 32'h0, 1'b0, "R10 no notify");
      bus_rd(A_RST, d); check("R9 report full", d, st(0,0,0,1,0));
      push_desc(64'h8000, 32'h20, 32'h0);
      retire(64'h99, 32'h0, 1'b0, "R10 no notify");
      bus_rd(A_RST, d); check("R9 report overflow error", d, st(0,0,0,1,1));
      bus_rd(A_DST, d); check("R9 desc still retired", d, st(1,1,1,0,0));
      bus_rd(A_RPORT, d); check("R9 report head kept", d, 32'h10);
   endtask

   initial begin
      #(20 * 100000);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_push_order();
      t_fill_overflow();
      t_retire();
      t_report_read();
      t_underflow();
      t_retire_empty();
      t_ring_reset();
      t_report_full();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule